// File: doc/BRIEF.md
# Keyboard Scan Code Command Decoder

This block sits behind a keyboard byte receiver. It takes the scan-code bytes that the receiver hands over as a valid/data stream and turns key presses into a small set of game commands: up, down, left, right, pause toggle, quit and select. A command stays on the output until the consumer acknowledges it with a one-cycle take strobe. With no command pending, the output carries a "none" code.

A four-state sequence machine follows the byte stream. IDLE is the resting state. GOT_E0 follows an extended-key prefix (0xE0). GOT_F0 follows a release prefix (0xF0). GOT_E0F0 follows a release prefix inside an extended sequence. Its transitions are:

- IDLE to GOT_F0 on 0xF0, and IDLE to GOT_E0 on 0xE0. Any other byte in IDLE is a press of a single-byte key and the state stays IDLE.
- GOT_E0 to GOT_E0F0 on 0xF0, and GOT_E0 to itself on a repeated 0xE0. Any other byte returns to IDLE.
- GOT_F0 to IDLE on any byte. That byte is a release.
- GOT_E0F0 to IDLE on any byte.

A hold guard records the code of the single key that is currently down. While that record is set, presses of any other key are dropped. Only a press that reaches an empty hold guard in IDLE can latch a command.

Top module: `kbd_cmd_decoder`

## Requirements
- R1: Reset sets cmd_code to 0 (none), returns the sequence machine to IDLE and clears the held-key record.
- R2: With no key held, a press byte in IDLE latches a command. The mapping is 0x1D→1 (up), 0x1B→2 (down), 0x1C→3 (left), 0x23→4 (right), 0x29→5 (pause toggle), 0x76→6 (quit) and 0x5A→7 (select). The code is visible the cycle after the byte.
- R3: A press of any other code latches no command, but it is recorded as the held key and blocks later presses until it is released.
- R4: The byte after 0xF0 never yields a command. If that byte equals the held key's code, the held-key record is cleared.
- R5: A sequence that begins with 0xE0 yields no command, whether it is a press or a release. It leaves the held-key record untouched.
- R6: While a key is held, a press of a different key, mapped or not, is dropped and changes nothing.
- R7: A repeated press of the held key itself latches no new command.
- R8: A latched command stays on cmd_code until cmd_take is high for one cycle. After that take, cmd_code reads 0.
- R9: A new command overwrites a pending one. If a new command and cmd_take arrive in the same cycle, the new command is latched.
- R10: A release of a key other than the held one leaves the held-key record in place.
- R11: A byte presented with key_valid low has no effect on cmd_code, the state or the held-key record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | key_byte carries a received byte this cycle |
| key_byte | input | 8 | Received scan-code byte |
| cmd_take | input | 1 | One-cycle acknowledge that clears the latched command |
| cmd_code | output | 3 | Latched command: 0 none, 1 up, 2 down, 3 left, 4 right, 5 pause, 6 quit, 7 select |

## Verification
Every result is due exactly one cycle after its stimulus. A byte or take strobe sampled at one rising edge changes cmd_code and the internal records at that same edge, so the new value is readable one clock later. The bench applies each vector on a falling edge and compares cmd_code on the next falling edge, so there is one registered step between stimulus and comparison. Effects on the held-key record that cmd_code cannot show directly are exposed through later vectors. These vectors send a mapped press that must either latch or stay dropped.

// File: rtl/kbd_cmd_pkg.sv
package kbd_cmd_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE   = 3'd0,
        CMD_UP     = 3'd1,
        CMD_DOWN   = 3'd2,
        CMD_LEFT   = 3'd3,
        CMD_RIGHT  = 3'd4,
        CMD_PAUSE  = 3'd5,
        CMD_QUIT   = 3'd6,
        CMD_SELECT = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GOT_E0   = 2'd1,
        ST_GOT_F0   = 2'd2,
        ST_GOT_E0F0 = 2'd3
    } seq_st_e;

    localparam logic [7:0] KEY_W     = 8'h1D;
    localparam logic [7:0] KEY_S     = 8'h1B;
    localparam logic [7:0] KEY_A     = 8'h1C;
    localparam logic [7:0] KEY_D     = 8'h23;
    localparam logic [7:0] KEY_SPACE = 8'h29;
    localparam logic [7:0] KEY_ESC   = 8'h76;
    localparam logic [7:0] KEY_ENTER = 8'h5A;

endpackage

// File: rtl/kbd_seq_fsm.sv
module kbd_seq_fsm
    import kbd_cmd_pkg::*;
#(
    parameter int             BYTE_W  = 8,
    parameter logic [BYTE_W-1:0] EXT_PFX = 8'hE0,
    parameter logic [BYTE_W-1:0] BRK_PFX = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output seq_st_e           state,
    output logic              make_evt,
    output logic              brk_evt,
    output logic [BYTE_W-1:0] evt_code
);

    seq_st_e state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state and event outputs
    always_comb begin
        state_nx = state;
        make_evt = 1'b0;
        brk_evt  = 1'b0;
        evt_code = in_byte;
        if (in_valid) begin
            unique case (state)
                ST_IDLE: begin
                    if (in_byte == BRK_PFX)      state_nx = ST_GOT_F0;
                    else if (in_byte == EXT_PFX) state_nx = ST_GOT_E0;
                    else                         make_evt = 1'b1;
                end
                ST_GOT_E0: begin
                    if (in_byte == BRK_PFX)      state_nx = ST_GOT_E0F0;
                    else if (in_byte == EXT_PFX) state_nx = ST_GOT_E0;
                    else                         state_nx = ST_IDLE;
                end
                ST_GOT_F0: begin
                    brk_evt  = 1'b1;
                    state_nx = ST_IDLE;
                end
                ST_GOT_E0F0: begin
                    state_nx = ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/kbd_code_map.sv
module kbd_code_map
    import kbd_cmd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] code,
    output cmd_e              cmd
);

    always_comb begin
        case (code)
            KEY_W:     cmd = CMD_UP;
            KEY_S:     cmd = CMD_DOWN;
            KEY_A:     cmd = CMD_LEFT;
            KEY_D:     cmd = CMD_RIGHT;
            KEY_SPACE: cmd = CMD_PAUSE;
            KEY_ESC:   cmd = CMD_QUIT;
            KEY_ENTER: cmd = CMD_SELECT;
            default:   cmd = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/kbd_hold_guard.sv
module kbd_hold_guard #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              make_evt,
    input  logic              brk_evt,
    input  logic [BYTE_W-1:0] evt_code,
    output logic              accept,
    output logic              held_vld,
    output logic [BYTE_W-1:0] held_code
);

    logic release_hit;

    assign accept      = make_evt && !held_vld;
    assign release_hit = brk_evt && held_vld && (evt_code == held_code);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_vld  <= 1'b0;
            held_code <= '0;
        end else if (accept) begin
            held_vld  <= 1'b1;
            held_code <= evt_code;
        end else if (release_hit) begin
            held_vld  <= 1'b0;
        end
    end

endmodule

// File: rtl/kbd_cmd_latch.sv
module kbd_cmd_latch
    import kbd_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  cmd_e load_cmd,
    input  logic take,
    output cmd_e cmd
);

    always_ff @(posedge clk) begin
        if (!rst_n)    cmd <= CMD_NONE;
        else if (load) cmd <= load_cmd;
        else if (take) cmd <= CMD_NONE;
    end

endmodule

// File: rtl/kbd_cmd_decoder.sv
module kbd_cmd_decoder
    import kbd_cmd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [BYTE_W-1:0] key_byte,
    input  logic              cmd_take,
    output logic [CMD_W-1:0]  cmd_code
);

    seq_st_e           fsm_state;
    logic              make_evt;
    logic              brk_evt;
    logic [BYTE_W-1:0] evt_code;
    logic              accept;
    logic              held_vld;
    logic [BYTE_W-1:0] held_code;
    cmd_e              mapped_cmd;
    cmd_e              latched_cmd;
    logic              load_cmd;

    kbd_seq_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (key_valid),
        .in_byte  (key_byte),
        .state    (fsm_state),
        .make_evt (make_evt),
        .brk_evt  (brk_evt),
        .evt_code (evt_code)
    );

    kbd_code_map #(.BYTE_W(BYTE_W)) u_map (
        .code (evt_code),
        .cmd  (mapped_cmd)
    );

    kbd_hold_guard #(.BYTE_W(BYTE_W)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .make_evt  (make_evt),
        .brk_evt   (brk_evt),
        .evt_code  (evt_code),
        .accept    (accept),
        .held_vld  (held_vld),
        .held_code (held_code)
    );

    assign load_cmd = accept && (mapped_cmd != CMD_NONE);

    kbd_cmd_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cmd),
        .load_cmd (mapped_cmd),
        .take     (cmd_take),
        .cmd      (latched_cmd)
    );

    assign cmd_code = latched_cmd;

endmodule

// File: rtl/kbd_cmd_decoder_chk.sv
module kbd_cmd_decoder_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_valid,
    input logic [BYTE_W-1:0] key_byte,
    input logic              cmd_take,
    input logic [2:0]        cmd_code,
    input logic [1:0]        st,
    input logic              held_vld,
    input logic [BYTE_W-1:0] held_code
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cmd_code == 3'd0)); // R1

    AST_HOLD_UNTIL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid && !cmd_take) |=> $stable(cmd_code)); // R8

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_take && !key_valid) |=> (cmd_code == 3'd0)); // R8

    AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && st != 2'd0 && !cmd_take) |=> $stable(cmd_code)); // R4

    AST_SECOND_KEY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && st == 2'd0 && held_vld && !cmd_take) |=> $stable(cmd_code)); // R6

    AST_BREAK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && st == 2'd2 && held_vld && key_byte == held_code) |=> !held_vld); // R4

    AST_EXT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && st == 2'd1 && key_byte != 8'hF0 && key_byte != 8'hE0)
        |=> (st == 2'd0 && $stable(held_vld))); // R5

endmodule

bind kbd_cmd_decoder kbd_cmd_decoder_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (key_valid),
    .key_byte  (key_byte),
    .cmd_take  (cmd_take),
    .cmd_code  (cmd_code),
    .st        (fsm_state),
    .held_vld  (held_vld),
    .held_code (held_code)
);

// File: tb/kbd_cmd_decoder_test.sv
module kbd_cmd_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 42;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [7:0] key_byte = 8'h00;
    logic       cmd_take = 1'b0;
    logic [2:0] cmd_code;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_cmd_decoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_byte  (key_byte),
        .cmd_take  (cmd_take),
        .cmd_code  (cmd_code)
    );

    // {req[3:0], valid, byte[7:0], take, expected[2:0]}
    localparam logic [16:0] VEC [0:NVEC-1] = '{
        {4'd2,  1'b1, 8'h1D, 1'b0, 3'd1},  // R2 W -> up
        {4'd4,  1'b1, 8'hF0, 1'b0, 3'd1},  // R4
        {4'd4,  1'b1, 8'h1D, 1'b0, 3'd1},  // R4 release W, no command
        {4'd8,  1'b0, 8'h00, 1'b1, 3'd0},  // R8 take
        {4'd2,  1'b1, 8'h1B, 1'b0, 3'd2},  // R2 S -> down
        {4'd6,  1'b1, 8'h1C, 1'b0, 3'd2},  // R6 A dropped
        {4'd10, 1'b1, 8'hF0, 1'b0, 3'd2},  // R10
        {4'd10, 1'b1, 8'h1C, 1'b0, 3'd2},  // R10 release of non-held A
        {4'd10, 1'b1, 8'h23, 1'b0, 3'd2},  // R10 S still held: D dropped
        {4'd4,  1'b1, 8'hF0, 1'b0, 3'd2},  // R4
        {4'd4,  1'b1, 8'h1B, 1'b0, 3'd2},  // R4 release S
        {4'd8,  1'b0, 8'h00, 1'b1, 3'd0},  // R8 take
        {4'd2,  1'b1, 8'h1C, 1'b0, 3'd3},  // R2 A -> left
        {4'd8,  1'b0, 8'h00, 1'b1, 3'd0},  // R8 take
        {4'd7,  1'b1, 8'h1C, 1'b0, 3'd0},  // R7 repeat of held A
        {4'd4,  1'b1, 8'hF0, 1'b0, 3'd0},  // R4
        {4'd4,  1'b1, 8'h1C, 1'b0, 3'd0},  // R4 release A
        {4'd5,  1'b1, 8'hE0, 1'b0, 3'd0},  // R5 extended prefix
        {4'd5,  1'b1, 8'h75, 1'b0, 3'd0},  // R5 extended press, no command
        {4'd5,  1'b1, 8'h23, 1'b0, 3'd4},  // R5 no hold from extended: D -> right
        {4'd4,  1'b1, 8'hF0, 1'b0, 3'd4},  // R4
        {4'd4,  1'b1, 8'h23, 1'b0, 3'd4},  // R4 release D
        {4'd5,  1'b1, 8'hE0, 1'b0, 3'd4},  // R5
        {4'd5,  1'b1, 8'hF0, 1'b0, 3'd4},  // R5
        {4'd5,  1'b1, 8'h1D, 1'b0, 3'd4},  // R5 extended release of W code, silent
        {4'd9,  1'b1, 8'h76, 1'b0, 3'd6},  // R9 ESC overwrites pending right
        {4'd4,  1'b1, 8'hF0, 1'b0, 3'd6},  // R4
        {4'd4,  1'b1, 8'h76, 1'b0, 3'd6},  // R4 release ESC
        {4'd9,  1'b1, 8'h29, 1'b1, 3'd5},  // R9 SPACE with take in same cycle
        {4'd4,  1'b1, 8'hF0, 1'b0, 3'd5},  // R4
        {4'd4,  1'b1, 8'h29, 1'b0, 3'd5},  // R4 release SPACE
        {4'd2,  1'b1, 8'h5A, 1'b0, 3'd7},  // R2 Enter -> select
        {4'd4,  1'b1, 8'hF0, 1'b0, 3'd7},  // R4
        {4'd4,  1'b1, 8'h5A, 1'b0, 3'd7},  // R4 release Enter
        {4'd8,  1'b0, 8'h00, 1'b1, 3'd0},  // R8 take
        {4'd3,  1'b1, 8'h15, 1'b0, 3'd0},  // R3 unmapped press
        {4'd3,  1'b1, 8'h1D, 1'b0, 3'd0},  // R3 unmapped key blocks W
        {4'd4,  1'b1, 8'hF0, 1'b0, 3'd0},  // R4
        {4'd4,  1'b1, 8'h15, 1'b0, 3'd0},  // R4 release unmapped key
        {4'd11, 1'b0, 8'h1D, 1'b0, 3'd0},  // R11 invalid byte ignored
        {4'd11, 1'b0, 8'hF0, 1'b0, 3'd0},  // R11 invalid prefix ignored
        {4'd11, 1'b1, 8'h1D, 1'b0, 3'd1}   // R11 state still IDLE: W -> up
    };

    task automatic check(input int req, input logic [2:0] got, input logic [2:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: cmd_code=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] b, input logic t);
        key_valid = v;
        key_byte  = b;
        cmd_take  = t;
        @(negedge clk);
        key_valid = 1'b0;
        cmd_take  = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(1, cmd_code, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, cmd_code, 3'd0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][12], VEC[i][11:4], VEC[i][3]);
            check(int'(VEC[i][16:13]), cmd_code, VEC[i][2:0]);
        end

        // R1: reset clears the latched command and the held record
        drive(1'b1, 8'hF0, 1'b0);
        drive(1'b1, 8'h1D, 1'b0);      // release W held from last vector
        drive(1'b1, 8'h1B, 1'b0);      // S held, down
        check(2, cmd_code, 3'd2);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, cmd_code, 3'd0);
        rst_n = 1'b1;
        drive(1'b1, 8'h1C, 1'b0);      // A accepted: S record cleared by reset
        check(1, cmd_code, 3'd3);

        // R1: reset returns the sequence machine to IDLE
        drive(1'b0, 8'h00, 1'b1);
        drive(1'b1, 8'hF0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 8'h23, 1'b0);      // treated as a press, not a release
        check(1, cmd_code, 3'd4);

        // R8: command persists across idle cycles without take
        repeat (5) @(negedge clk);
        check(8, cmd_code, 3'd4);

        finish_run();
    end

endmodule